// File: doc/BRIEF.md
# Memory card access steering decoder

This block sits behind the host-side pins of a 16-bit removable flash memory card. Each clock it looks at the two byte-lane card enables, the output and write strobes, the register-select line and the 26-bit address. From these it works out which memory space is addressed (the flash array or the attribute space), which byte lanes take part, whether a lone byte is the odd or the even one, and where in the flash array the access lands: device pair, bank, block and offset inside the block.

It drives one active-low chip enable per flash device (up to six pairs, an even-byte device and an odd-byte device in each pair), a select for the attribute space, and the output enables of the two data-bus lanes with a steering bit that routes the odd device onto the low lane. When a driven lane must not carry memory data (an odd byte in attribute space, or an array access beyond the fitted capacity with the fill option on), a per-lane fill flag tells the data path to drive a fixed pattern. All outputs are registered, so they follow the inputs by one clock.

The control pins are plain levels: there is no data stream through the block and no back-pressure.

Top module: `card_steer_dec`

## Requirements
- R1: With both card enables high (standby), or with output and write strobes both low (conflict), every device chip enable is high, the attribute select is 0 and both lane output enables are 0.
- R2: With only the low enable asserted in array space, address bit 0 picks the device: 0 selects the even device of the pair (device index 2*pair), 1 the odd device (2*pair+1); only the low lane is used and the low-lane steering bit equals address bit 0.
- R3: With only the high enable asserted in array space, the odd device (2*pair+1) is enabled, only the high lane is used, and the low lane stays undriven.
- R4: With both enables asserted in array space, address bit 0 is ignored, both devices of the pair are enabled, the low lane carries the even device (steering bit 0) and the high lane carries the odd device.
- R5: The offset output equals address bits 16..1, the block output bits 21..17, the bank output bit 22 and the pair output bits 25..23 (reduced modulo the fitted pair count when the fill option is off).
- R6: Register-select low selects attribute space: attribute select 1, no device chip enable; on a read, a driven lane carrying an odd byte (low lane with address bit 0 set, or the high lane) has its fill flag set.
- R7: With the fill option on, an array access whose pair index is not below the fitted pair count enables no device, and every lane it reads from has its fill flag set; with the option off the pair index wraps onto a fitted pair.
- R8: A lane output enable is 1 only when output strobe is low, write strobe is high and that lane's card enable is asserted; writes enable devices but never drive a lane.
- R9: During reset every chip enable is high, all select, enable, steering and fill outputs are 0, and after reset every output reflects the inputs of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel_n | input | 1 | Low selects attribute space |
| ce_lo_n | input | 1 | Low-lane card enable, active low |
| ce_hi_n | input | 1 | High-lane card enable, active low |
| oe_n | input | 1 | Output (read) strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 26 | Host byte address |
| dev_ce_n | output | 12 | Per-device chip enable, active low, even device at index 2*pair |
| attr_cs | output | 1 | Attribute space selected |
| pair_idx | output | 3 | Decoded device pair |
| bank_idx | output | 1 | Decoded bank |
| block_idx | output | 5 | Decoded block in the bank |
| blk_off | output | 16 | Word offset inside the block |
| lo_oe | output | 1 | Drive data bits 7..0 |
| hi_oe | output | 1 | Drive data bits 15..8 |
| lo_from_odd | output | 1 | Low lane carries the odd device |
| lo_fill | output | 1 | Low lane carries the fixed pattern |
| hi_fill | output | 1 | High lane carries the fixed pattern |

## Verification
The bench drives the standby and strobe-conflict cases, each of the three lane patterns (low only with both values of address bit 0, high only, both) in array space, the same patterns in attribute space, and addresses whose pair field lies above the fitted count. The lane patterns tell apart steering mistakes such as an odd byte landing on the wrong lane or a word access honouring address bit 0; the attribute and out-of-range cases separate real device selection from the fill path, and a second instance with the fill option off shows that high pair indices wrap instead. A long run of random inputs is compared every clock against a behavioural model.

// File: rtl/card_steer_pkg.sv
package card_steer_pkg;
  localparam int AW        = 26;
  localparam int OFF_W     = 16;
  localparam int BLK_W     = 5;
  localparam int BANK_W    = 1;
  localparam int PAIR_W    = 3;
  localparam int OFF_LSB   = 1;
  localparam int BLK_LSB   = OFF_LSB + OFF_W;
  localparam int BANK_LSB  = BLK_LSB + BLK_W;
  localparam int PAIR_LSB  = BANK_LSB + BANK_W;

  typedef struct packed {
    logic lo_en;    // low lane takes part
    logic hi_en;    // high lane takes part
    logic even_dev; // even device of the pair used
    logic odd_dev;  // odd device of the pair used
    logic lo_odd;   // low lane fed from odd device
  } lane_t;
endpackage

// File: rtl/lane_steer.sv
module lane_steer
  import card_steer_pkg::*;
(
  input  logic  ce_lo_n,
  input  logic  ce_hi_n,
  input  logic  a0,
  output lane_t lane
);
  always_comb begin
    lane = '0;
    unique case ({ce_hi_n, ce_lo_n})
      2'b10: begin // low lane only: byte access
        lane.lo_en    = 1'b1;
        lane.lo_odd   = a0;
        lane.even_dev = ~a0;
        lane.odd_dev  = a0;
      end
      2'b01: begin // high lane only: odd byte
        lane.hi_en   = 1'b1;
        lane.odd_dev = 1'b1;
      end
      2'b00: begin // word access, a0 ignored
        lane.lo_en    = 1'b1;
        lane.hi_en    = 1'b1;
        lane.even_dev = 1'b1;
        lane.odd_dev  = 1'b1;
      end
      default: lane = '0;
    endcase
  end
endmodule

// File: rtl/addr_split.sv
module addr_split
  import card_steer_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter bit OOR_FILL  = 1'b1
) (
  input  logic [AW-1:0]     addr,
  output logic [OFF_W-1:0]  off,
  output logic [BLK_W-1:0]  blk,
  output logic [BANK_W-1:0] bank,
  output logic [PAIR_W-1:0] pair,
  output logic              in_range
);
  logic [PAIR_W-1:0] raw_pair;

  assign off      = addr[OFF_LSB  +: OFF_W];
  assign blk      = addr[BLK_LSB  +: BLK_W];
  assign bank     = addr[BANK_LSB +: BANK_W];
  assign raw_pair = addr[PAIR_LSB +: PAIR_W];

  generate
    if (OOR_FILL) begin : g_fill
      assign pair     = raw_pair;
      assign in_range = (32'(raw_pair) < NUM_PAIRS);
    end else begin : g_alias
      assign pair     = PAIR_W'(32'(raw_pair) % NUM_PAIRS);
      assign in_range = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/dev_select.sv
module dev_select
  import card_steer_pkg::*;
#(
  parameter int MAX_PAIRS = 6
) (
  input  logic                   hit,
  input  logic [PAIR_W-1:0]      pair,
  input  lane_t                  lane,
  output logic [2*MAX_PAIRS-1:0] ce_n
);
  for (genvar p = 0; p < MAX_PAIRS; p++) begin : g_pair
    logic pick;
    assign pick          = hit && (32'(pair) == p);
    assign ce_n[2*p]     = ~(pick && lane.even_dev);
    assign ce_n[2*p + 1] = ~(pick && lane.odd_dev);
  end
endmodule

// File: rtl/card_steer_dec.sv
module card_steer_dec
  import card_steer_pkg::*;
#(
  parameter int MAX_PAIRS = 6,
  parameter int NUM_PAIRS = 6,
  parameter bit OOR_FILL  = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_sel_n,
  input  logic                   ce_lo_n,
  input  logic                   ce_hi_n,
  input  logic                   oe_n,
  input  logic                   we_n,
  input  logic [AW-1:0]          addr,
  output logic [2*MAX_PAIRS-1:0] dev_ce_n,
  output logic                   attr_cs,
  output logic [PAIR_W-1:0]      pair_idx,
  output logic [BANK_W-1:0]      bank_idx,
  output logic [BLK_W-1:0]       block_idx,
  output logic [OFF_W-1:0]       blk_off,
  output logic                   lo_oe,
  output logic                   hi_oe,
  output logic                   lo_from_odd,
  output logic                   lo_fill,
  output logic                   hi_fill
);
  localparam int NDEV = 2 * MAX_PAIRS;

  lane_t             lane;
  logic [OFF_W-1:0]  off_c;
  logic [BLK_W-1:0]  blk_c;
  logic [BANK_W-1:0] bank_c;
  logic [PAIR_W-1:0] pair_c;
  logic              in_range;
  logic              active, rd, attr_c, mem_hit, oor_c;
  logic [NDEV-1:0]   ce_n_c;

  lane_steer u_lane (
    .ce_lo_n (ce_lo_n),
    .ce_hi_n (ce_hi_n),
    .a0      (addr[0]),
    .lane    (lane)
  );

  addr_split #(.NUM_PAIRS(NUM_PAIRS), .OOR_FILL(OOR_FILL)) u_split (
    .addr     (addr),
    .off      (off_c),
    .blk      (blk_c),
    .bank     (bank_c),
    .pair     (pair_c),
    .in_range (in_range)
  );

  assign active  = (lane.lo_en || lane.hi_en) && !(!oe_n && !we_n);
  assign rd      = active && !oe_n && we_n;
  assign attr_c  = active && !reg_sel_n;
  assign mem_hit = active && reg_sel_n && in_range;
  assign oor_c   = active && reg_sel_n && !in_range;

  dev_select #(.MAX_PAIRS(MAX_PAIRS)) u_sel (
    .hit  (mem_hit),
    .pair (pair_c),
    .lane (lane),
    .ce_n (ce_n_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_ce_n    <= '1;
      attr_cs     <= 1'b0;
      pair_idx    <= '0;
      bank_idx    <= '0;
      block_idx   <= '0;
      blk_off     <= '0;
      lo_oe       <= 1'b0;
      hi_oe       <= 1'b0;
      lo_from_odd <= 1'b0;
      lo_fill     <= 1'b0;
      hi_fill     <= 1'b0;
    end else begin
      dev_ce_n    <= ce_n_c;
      attr_cs     <= attr_c;
      pair_idx    <= pair_c;
      bank_idx    <= bank_c;
      block_idx   <= blk_c;
      blk_off     <= off_c;
      lo_oe       <= rd && lane.lo_en;
      hi_oe       <= rd && lane.hi_en;
      lo_from_odd <= active && lane.lo_odd;
      lo_fill     <= rd && lane.lo_en && (oor_c || (attr_c && lane.lo_odd));
      hi_fill     <= rd && lane.hi_en && (oor_c || attr_c);
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce_lo_n && ce_hi_n) || $past(!oe_n && !we_n))
      |-> (&dev_ce_n && !attr_cs && !lo_oe && !hi_oe));

  // R6
  attr_no_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attr_cs |-> &dev_ce_n);

  // R3
  hi_only_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_lo_n && !ce_hi_n) |-> !lo_oe);

  // R8
  lane_drive_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_oe || hi_oe) |-> $past(!oe_n && we_n));

  // R2
  two_dev_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dev_ce_n) <= 2);
endmodule

// File: tb/card_steer_dec_tb.sv
module card_steer_dec_tb;
  import card_steer_pkg::*;

  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel_n = 1'b1, ce_lo_n = 1'b1, ce_hi_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;

  logic [11:0] a_ce, b_ce;
  logic a_attr, b_attr, a_lo, b_lo, a_hi, b_hi, a_odd, b_odd, a_lf, b_lf, a_hf, b_hf;
  logic [2:0] a_pair, b_pair;
  logic a_bank, b_bank;
  logic [4:0] a_blk, b_blk;
  logic [15:0] a_off, b_off;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  card_steer_dec #(.MAX_PAIRS(6), .NUM_PAIRS(NP), .OOR_FILL(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel_n(reg_sel_n), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .dev_ce_n(a_ce), .attr_cs(a_attr),
    .pair_idx(a_pair), .bank_idx(a_bank), .block_idx(a_blk), .blk_off(a_off),
    .lo_oe(a_lo), .hi_oe(a_hi), .lo_from_odd(a_odd), .lo_fill(a_lf), .hi_fill(a_hf));

  card_steer_dec #(.MAX_PAIRS(6), .NUM_PAIRS(NP), .OOR_FILL(1'b0)) u_dut_alias (
    .clk(clk), .rst_n(rst_n), .reg_sel_n(reg_sel_n), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .dev_ce_n(b_ce), .attr_cs(b_attr),
    .pair_idx(b_pair), .bank_idx(b_bank), .block_idx(b_blk), .blk_off(b_off),
    .lo_oe(b_lo), .hi_oe(b_hi), .lo_from_odd(b_odd), .lo_fill(b_lf), .hi_fill(b_hf));

  // Behavioural model: returns {ce_n[11:0], attr, lo_oe, hi_oe, lo_odd, lo_fill, hi_fill}
  function automatic logic [17:0] model(input bit fill_opt, input logic rs_n, input logic cl_n,
                                        input logic ch_n, input logic o_n, input logic w_n,
                                        input logic [AW-1:0] a);
    logic [11:0] ce = 12'hFFF;
    bit lo_use = !cl_n;
    bit hi_use = !ch_n;
    bit act = (lo_use || hi_use) && !(!o_n && !w_n);
    bit rd = act && !o_n && w_n;
    bit attr = act && !rs_n;
    int pr = int'(a[25:23]);
    bit oor = 0;
    bit lodd = 0;
    bit lf = 0;
    bit hf = 0;
    if (fill_opt) oor = (pr >= NP); else pr = pr % NP;
    if (lo_use && !hi_use) lodd = a[0];
    if (act && rs_n && !oor) begin
      if (lo_use && hi_use) begin ce[2*pr] = 1'b0; ce[2*pr+1] = 1'b0; end
      else if (hi_use) ce[2*pr+1] = 1'b0;
      else ce[2*pr + int'(a[0])] = 1'b0;
    end
    if (rd && lo_use) lf = (rs_n && oor) || (attr && lodd);
    if (rd && hi_use) hf = (rs_n && oor) || attr;
    return {ce, attr, rd && lo_use, rd && hi_use, act && lodd, lf, hf};
  endfunction

  function automatic string tag_of(input logic rs_n, input logic cl_n, input logic ch_n,
                                   input logic o_n, input logic w_n, input logic [AW-1:0] a);
    if ((cl_n && ch_n) || (!o_n && !w_n)) return "R1";
    if (!rs_n) return "R6";
    if (int'(a[25:23]) >= NP) return "R7";
    if (!o_n && w_n) begin
      if (!cl_n && !ch_n) return "R4";
      if (!ch_n) return "R3";
      return "R2";
    end
    return "R8";
  endfunction

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rs_n, input logic cl_n, input logic ch_n,
                      input logic o_n, input logic w_n, input logic [AW-1:0] a);
    logic [17:0] ea, eb;
    logic [2:0] pb;
    string t;
    @(negedge clk);
    reg_sel_n = rs_n; ce_lo_n = cl_n; ce_hi_n = ch_n; oe_n = o_n; we_n = w_n; addr = a;
    ea = model(1'b1, rs_n, cl_n, ch_n, o_n, w_n, a);
    eb = model(1'b0, rs_n, cl_n, ch_n, o_n, w_n, a);
    pb = 3'(int'(a[25:23]) % NP);
    t = tag_of(rs_n, cl_n, ch_n, o_n, w_n, a);
    @(posedge clk);
    #2;
    cmp(t, 64'({a_ce, a_attr, a_lo, a_hi, a_odd, a_lf, a_hf}), 64'(ea));
    // R7 alias instance wraps the pair index instead of filling
    cmp("R7", 64'({b_ce, b_attr, b_lo, b_hi, b_odd, b_lf, b_hf}), 64'(eb));
    // R5 address field split
    cmp("R5", 64'({a_pair, a_bank, a_blk, a_off}), 64'({a[25:23], a[22], a[21:17], a[16:1]}));
    cmp("R5", 64'(b_pair), 64'(pb));
  endtask

  function automatic logic [AW-1:0] mk(input int pr, input int bk, input int bl, input int off, input int b0);
    return {3'(pr), 1'(bk), 5'(bl), 16'(off), 1'(b0)};
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    // drive an active read during reset: outputs must stay in reset state
    reg_sel_n = 1'b1; ce_lo_n = 1'b0; ce_hi_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = mk(1, 0, 3, 7, 0);
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    cmp("R9", 64'({a_ce, a_attr, a_lo, a_hi, a_odd, a_lf, a_hf}), 64'({12'hFFF, 6'b0}));
    cmp("R9", 64'({a_pair, a_bank, a_blk, a_off}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 standby and strobe conflict
    step(1, 1, 1, 0, 1, mk(2, 1, 4, 100, 0));
    step(1, 0, 0, 0, 0, mk(2, 1, 4, 100, 0));
    // R2 byte mode, even then odd
    step(1, 0, 1, 0, 1, mk(3, 0, 9, 16'h1234, 0));
    step(1, 0, 1, 0, 1, mk(3, 0, 9, 16'h1234, 1));
    // R3 high lane only
    step(1, 1, 0, 0, 1, mk(0, 1, 31, 16'hFFFF, 0));
    // R4 word mode, a0 both values
    step(1, 0, 0, 0, 1, mk(4, 0, 1, 5, 0));
    step(1, 0, 0, 0, 1, mk(4, 0, 1, 5, 1));
    // R8 writes drive no lane
    step(1, 0, 0, 1, 0, mk(1, 1, 2, 3, 0));
    step(1, 0, 1, 1, 1, mk(1, 1, 2, 3, 1));
    // R6 attribute space
    step(0, 0, 1, 0, 1, mk(0, 0, 0, 16'h2000, 0));
    step(0, 0, 1, 0, 1, mk(0, 0, 0, 16'h2000, 1));
    step(0, 0, 0, 0, 1, mk(0, 0, 0, 16'h2001, 0));
    step(0, 1, 0, 0, 1, mk(0, 0, 0, 16'h2001, 1));
    // R7 beyond capacity (pairs 5..7 with 5 fitted)
    step(1, 0, 0, 0, 1, mk(5, 0, 0, 0, 0));
    step(1, 0, 1, 0, 1, mk(7, 1, 3, 9, 1));
    step(1, 0, 0, 1, 0, mk(6, 0, 0, 0, 0));
    step(1, 1, 0, 0, 1, mk(4, 0, 0, 0, 0));

    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(($urandom % 4) != 0, r[0], r[1], r[2] & r[3], ($urandom % 3) == 0 ? 1'b0 : 1'b1,
           AW'($urandom));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule